// File: doc/BRIEF.md
# Range-Based Memory Protection Checker

This block sits beside one processor and decides, in the same cycle, whether an access is allowed. The access can be an instruction fetch, a data load or a data store. There are two pools of address windows, and each window has a lower and an upper bound. Code windows cover fetches. Data windows cover loads and stores. Data windows apply to any address, so one window can cover a peripheral register block in the same way it covers a RAM area. Every window is checked in parallel.

Permissions do not live in the windows. They live in four switchable permission sets. Each set holds one execute bit for every code window, and one read bit and one write bit for every data window. Software picks the active set through a register. By convention, set 0 serves background tasks and set 1 serves interrupt handlers. An access that no window of the active set allows is denied. The first denial is latched as a sticky trap record: the kind of violation and the faulting address. The record stays until software clears it.

The bounds, the enables, the set select and the trap clear are all written through a simple write-only register port.

Top module: `prot_checker`

## Requirements
- R1: The block has 8 code windows and 16 data windows. An address A lies in a window when lower <= A < upper. Bounds are written from cfg_wdata bits [31:3], so bits [2:0] of a written bound are ignored.
- R2: There are 4 permission sets. Each set has 8 execute bits, where bit i refers to code window i. Each set also has 16 read bits and 16 write bits, where bit i refers to data window i.
- R3: An access is granted only when some window of the right pool contains the address and the active set has the matching bit for that window. Every other access is denied. After reset all bounds and enables are zero, so every access is denied.
- R4: acc_grant and acc_deny answer in the same cycle as acc_valid, with no register in between. When acc_valid is low, both outputs are 0.
- R5: acc_kind 0 is a fetch, 1 is a load, and 2 or 3 is a store. The trap kind codes are: 1 for a read violation, 2 for a write violation, 3 for an execute violation, and 0 after reset.
- R6: A denial while no trap is pending sets trap_pending, trap_kind and trap_addr. They are visible from the next cycle. Later denials do not change them while the trap stays pending.
- R7: Writing the clear address drops trap_pending from the next cycle, and trap_kind and trap_addr keep their values. If a denial arrives in the same cycle as the clear, that denial is captured instead.
- R8: The active set comes from cfg_wdata[1:0] written to the set-select address. The new set applies from the cycle after the write.
- R9: The register map is:
  - code window i bounds at 2i (lower) and 2i+1 (upper);
  - data window i bounds at 0x20+2i (lower) and 0x21+2i (upper);
  - execute bits of set s at 0x40+s;
  - read bits of set s at 0x48+s;
  - write bits of set s at 0x50+s;
  - set select at 0x58;
  - trap clear at 0x59.

  Writes to any other address, to a window index that does not exist, or to a set number that does not exist change nothing.
- R10: Fetches are checked only against code windows. Loads and stores are checked only against data windows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 7 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 0 fetch, 1 load, 2/3 store |
| acc_addr | input | 32 | Access address |
| acc_grant | output | 1 | Access allowed |
| acc_deny | output | 1 | Access refused |
| trap_pending | output | 1 | Sticky trap record valid |
| trap_kind | output | 2 | Kind of the captured violation |
| trap_addr | output | 32 | Address of the captured violation |

## Verification
The hardest case to reach is the moment software clears the trap record while a new denial arrives in that very cycle. The stimulus reaches it by driving the clear write and a refused load in the same cycle, then checking that the new address is the one recorded.

Window edges are hit with directed probes at lower, upper-minus-four and upper, using bounds whose low bits are deliberately nonzero. Switching sets is exercised with one window that is read-only in set 0 and write-only in set 1.

A long stretch of random register writes and accesses then confronts a behavioural model every cycle. Those writes include ones to missing windows and sets.

// File: rtl/prc_pkg.sv
package prc_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_STALT = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    TRAP_NONE  = 2'd0,
    TRAP_READ  = 2'd1,
    TRAP_WRITE = 2'd2,
    TRAP_EXEC  = 2'd3
  } trap_kind_e;

  localparam int unsigned CFG_AW   = 7;
  localparam logic [1:0]  GRP_CODE = 2'b00;
  localparam logic [1:0]  GRP_DATA = 2'b01;
  localparam logic [3:0]  GRP_XEN  = 4'h8;
  localparam logic [3:0]  GRP_REN  = 4'h9;
  localparam logic [3:0]  GRP_WEN  = 4'hA;
  localparam logic [6:0]  SEL_ADDR = 7'h58;
  localparam logic [6:0]  CLR_ADDR = 7'h59;

endpackage

// File: rtl/prc_range_bank.sv
module prc_range_bank #(
  parameter int unsigned N   = 8,
  parameter int unsigned AW  = 32,
  parameter int unsigned LSB = 3,
  localparam int unsigned BW = AW - LSB
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic          wr_upper,
  input  logic [BW-1:0] wr_bound,
  input  logic [AW-1:0] probe_addr,
  output logic [N-1:0]  hit
);

  logic [BW-1:0] probe_blk;
  logic          unused_low;

  assign probe_blk  = probe_addr[AW-1:LSB];
  assign unused_low = ^probe_addr[LSB-1:0];

  for (genvar i = 0; i < N; i++) begin : g_win
    logic [BW-1:0] lo_q, lo_d, hi_q, hi_d;
    logic          lo_we, hi_we;

    assign lo_we = wr_en && (wr_idx == 4'(i)) && !wr_upper;
    assign hi_we = wr_en && (wr_idx == 4'(i)) &&  wr_upper;

    always_comb begin
      lo_d = lo_we ? wr_bound : lo_q;
      hi_d = hi_we ? wr_bound : hi_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q <= '0;
        hi_q <= '0;
      end else begin
        if (lo_we) lo_q <= lo_d;
        if (hi_we) hi_q <= hi_d;
      end
    end

    assign hit[i] = (probe_blk >= lo_q) && (probe_blk < hi_q);
  end

endmodule

// File: rtl/prc_perm_sets.sv
module prc_perm_sets
  import prc_pkg::*;
#(
  parameter int unsigned N_CODE = 8,
  parameter int unsigned N_DATA = 16,
  parameter int unsigned N_SETS = 4,
  parameter int unsigned DW     = 32,
  localparam int unsigned SW    = (N_SETS > 1) ? $clog2(N_SETS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CFG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [N_CODE-1:0] act_x,
  output logic [N_DATA-1:0] act_r,
  output logic [N_DATA-1:0] act_w
);

  logic [N_SETS*N_CODE-1:0] x_flat;
  logic [N_SETS*N_DATA-1:0] r_flat, w_flat;
  logic [SW-1:0]            sel_q, sel_d;
  logic                     sel_we;
  logic                     unused_data;

  assign unused_data = ^wr_data;

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    logic [N_CODE-1:0] x_q, x_d;
    logic [N_DATA-1:0] r_q, r_d, w_q, w_d;
    logic              x_we, r_we, w_we;

    assign x_we = wr_en && (wr_addr[6:3] == GRP_XEN) && (wr_addr[2:0] == 3'(s));
    assign r_we = wr_en && (wr_addr[6:3] == GRP_REN) && (wr_addr[2:0] == 3'(s));
    assign w_we = wr_en && (wr_addr[6:3] == GRP_WEN) && (wr_addr[2:0] == 3'(s));

    always_comb begin
      x_d = x_we ? wr_data[N_CODE-1:0] : x_q;
      r_d = r_we ? wr_data[N_DATA-1:0] : r_q;
      w_d = w_we ? wr_data[N_DATA-1:0] : w_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        x_q <= '0;
        r_q <= '0;
        w_q <= '0;
      end else begin
        if (x_we) x_q <= x_d;
        if (r_we) r_q <= r_d;
        if (w_we) w_q <= w_d;
      end
    end

    assign x_flat[s*N_CODE +: N_CODE] = x_q;
    assign r_flat[s*N_DATA +: N_DATA] = r_q;
    assign w_flat[s*N_DATA +: N_DATA] = w_q;
  end

  assign sel_we = wr_en && (wr_addr == SEL_ADDR) &&
                  ({1'b0, wr_data[SW-1:0]} < (SW+1)'(N_SETS));

  always_comb begin
    sel_d = sel_we ? wr_data[SW-1:0] : sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= sel_d;
  end

  always_comb begin
    act_x = x_flat[int'(sel_q)*N_CODE +: N_CODE];
    act_r = r_flat[int'(sel_q)*N_DATA +: N_DATA];
    act_w = w_flat[int'(sel_q)*N_DATA +: N_DATA];
  end

  // R8: the active set only moves on a set-select write
  p_sel_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (wr_addr == SEL_ADDR)) |=> $stable(sel_q));

endmodule

// File: rtl/prc_trap_capture.sv
module prc_trap_capture
  import prc_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deny,
  input  trap_kind_e    deny_kind,
  input  logic [AW-1:0] deny_addr,
  input  logic          clr,
  output logic          pending,
  output trap_kind_e    kind,
  output logic [AW-1:0] addr
);

  logic          pend_q, pend_d;
  trap_kind_e    kind_q, kind_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          cap, upd;

  assign cap = deny && (!pend_q || clr);
  assign upd = cap || clr;

  always_comb begin
    pend_d = pend_q;
    kind_d = kind_q;
    addr_d = addr_q;
    if (cap) begin
      pend_d = 1'b1;
      kind_d = deny_kind;
      addr_d = deny_addr;
    end else if (clr) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      kind_q <= TRAP_NONE;
      addr_q <= '0;
    end else if (upd) begin
      pend_q <= pend_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
    end
  end

  assign pending = pend_q;
  assign kind    = kind_q;
  assign addr    = addr_q;

  // R6: a first denial is recorded on the next cycle
  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (deny && (!pend_q || clr)) |=>
      (pend_q && (addr_q == $past(deny_addr)) && (kind_q == $past(deny_kind))));

  // R6: a pending record is frozen until cleared
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr) |=> (pend_q && $stable(addr_q) && $stable(kind_q)));

  // R7: clear without a new denial drops the pending flag
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !deny) |=> !pend_q);

endmodule

// File: rtl/prot_checker.sv
module prot_checker
  import prc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned N_CODE = 8,
  parameter int unsigned N_DATA = 16,
  parameter int unsigned N_SETS = 4,
  parameter int unsigned ALIGN  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [6:0]        cfg_addr,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              acc_valid,
  input  logic [1:0]        acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              acc_grant,
  output logic              acc_deny,
  output logic              trap_pending,
  output logic [1:0]        trap_kind,
  output logic [ADDR_W-1:0] trap_addr
);

  localparam int unsigned BW = ADDR_W - ALIGN;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              code_wr, data_wr, clr_wr;
  logic [N_CODE-1:0] code_hit, act_x;
  logic [N_DATA-1:0] data_hit, act_r, act_w;
  logic              code_ok, rd_ok, wr_ok, allowed;
  acc_kind_e         kind_in;
  trap_kind_e        deny_kind, cap_kind;
  logic              unused_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign code_wr    = cfg_we && (cfg_addr[6:5] == GRP_CODE);
  assign data_wr    = cfg_we && (cfg_addr[6:5] == GRP_DATA);
  assign clr_wr     = cfg_we && (cfg_addr == CLR_ADDR);
  assign unused_cfg = ^cfg_wdata[ALIGN-1:0];

  prc_range_bank #(.N(N_CODE), .AW(ADDR_W), .LSB(ALIGN)) u_code (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (code_wr),
    .wr_idx     (cfg_addr[4:1]),
    .wr_upper   (cfg_addr[0]),
    .wr_bound   (cfg_wdata[ADDR_W-1:ALIGN]),
    .probe_addr (acc_addr),
    .hit        (code_hit)
  );

  prc_range_bank #(.N(N_DATA), .AW(ADDR_W), .LSB(ALIGN)) u_data (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (data_wr),
    .wr_idx     (cfg_addr[4:1]),
    .wr_upper   (cfg_addr[0]),
    .wr_bound   (cfg_wdata[ADDR_W-1:ALIGN]),
    .probe_addr (acc_addr),
    .hit        (data_hit)
  );

  prc_perm_sets #(.N_CODE(N_CODE), .N_DATA(N_DATA), .N_SETS(N_SETS), .DW(ADDR_W)) u_perm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_wdata),
    .act_x   (act_x),
    .act_r   (act_r),
    .act_w   (act_w)
  );

  assign kind_in = acc_kind_e'(acc_kind);
  assign code_ok = |(code_hit & act_x);
  assign rd_ok   = |(data_hit & act_r);
  assign wr_ok   = |(data_hit & act_w);

  always_comb begin
    unique case (kind_in)
      ACC_FETCH: begin allowed = code_ok; deny_kind = TRAP_EXEC;  end
      ACC_LOAD:  begin allowed = rd_ok;   deny_kind = TRAP_READ;  end
      default:   begin allowed = wr_ok;   deny_kind = TRAP_WRITE; end
    endcase
  end

  assign acc_grant = acc_valid &&  allowed;
  assign acc_deny  = acc_valid && !allowed;

  prc_trap_capture #(.AW(ADDR_W)) u_trap (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .deny      (acc_deny),
    .deny_kind (deny_kind),
    .deny_addr (acc_addr),
    .clr       (clr_wr),
    .pending   (trap_pending),
    .kind      (cap_kind),
    .addr      (trap_addr)
  );

  assign trap_kind = cap_kind;

  // R5: kind recorded for each access class
  p_exec_kind_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_deny && !trap_pending && (acc_kind == 2'd0)) |=> (trap_kind == 2'd3));
  p_read_kind_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_deny && !trap_pending && (acc_kind == 2'd1)) |=> (trap_kind == 2'd1));
  p_write_kind_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_deny && !trap_pending && acc_kind[1]) |=> (trap_kind == 2'd2));

endmodule

// File: tb/prot_checker_tb_top.sv
module prot_checker_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [6:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic        acc_valid;
  logic [1:0]  acc_kind;
  logic [31:0] acc_addr;
  logic        acc_grant, acc_deny, trap_pending;
  logic [1:0]  trap_kind;
  logic [31:0] trap_addr;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    cmp_on  = 1'b0;
  bit    done    = 1'b0;
  string cur_tag = "R3";

  always #(CLK_PERIOD/2) clk = ~clk;

  prot_checker dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .acc_valid(acc_valid), .acc_kind(acc_kind),
    .acc_addr(acc_addr), .acc_grant(acc_grant), .acc_deny(acc_deny),
    .trap_pending(trap_pending), .trap_kind(trap_kind), .trap_addr(trap_addr)
  );

  // behavioural reference model
  logic [28:0] m_clo [8];
  logic [28:0] m_chi [8];
  logic [28:0] m_dlo [16];
  logic [28:0] m_dhi [16];
  logic [7:0]  m_x [4];
  logic [15:0] m_r [4];
  logic [15:0] m_w [4];
  int          m_set;
  logic        m_pend;
  logic [1:0]  m_kind;
  logic [31:0] m_taddr;

  function automatic bit m_ok(input logic [1:0] k, input logic [31:0] a);
    logic [28:0] p;
    bit ok;
    p  = a[31:3];
    ok = 1'b0;
    if (k == 2'd0) begin
      for (int i = 0; i < 8; i++)
        if (m_x[m_set][i] && p >= m_clo[i] && p < m_chi[i]) ok = 1'b1;
    end else begin
      for (int i = 0; i < 16; i++) begin
        bit en;
        en = k[1] ? m_w[m_set][i] : m_r[m_set][i];
        if (en && p >= m_dlo[i] && p < m_dhi[i]) ok = 1'b1;
      end
    end
    return ok;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin m_clo[i] <= '0; m_chi[i] <= '0; end
      for (int i = 0; i < 16; i++) begin m_dlo[i] <= '0; m_dhi[i] <= '0; end
      for (int s = 0; s < 4; s++) begin m_x[s] <= '0; m_r[s] <= '0; m_w[s] <= '0; end
      m_set <= 0; m_pend <= 1'b0; m_kind <= 2'd0; m_taddr <= '0;
    end else begin
      bit dn, cl;
      int ix;
      dn = acc_valid && !m_ok(acc_kind, acc_addr);
      cl = cfg_we && (cfg_addr == 7'h59);
      if (dn && (!m_pend || cl)) begin
        m_pend  <= 1'b1;
        m_kind  <= (acc_kind == 2'd0) ? 2'd3 : (acc_kind[1] ? 2'd2 : 2'd1);
        m_taddr <= acc_addr;
      end else if (cl) begin
        m_pend <= 1'b0;
      end
      if (cfg_we) begin
        if (cfg_addr < 7'h20) begin
          ix = int'(cfg_addr) / 2;
          if (ix < 8) begin
            if (cfg_addr[0]) m_chi[ix] <= cfg_wdata[31:3];
            else             m_clo[ix] <= cfg_wdata[31:3];
          end
        end else if (cfg_addr < 7'h40) begin
          ix = (int'(cfg_addr) - 32) / 2;
          if (cfg_addr[0]) m_dhi[ix] <= cfg_wdata[31:3];
          else             m_dlo[ix] <= cfg_wdata[31:3];
        end else if (cfg_addr < 7'h44) m_x[int'(cfg_addr) - 64] <= cfg_wdata[7:0];
        else if (cfg_addr >= 7'h48 && cfg_addr < 7'h4C) m_r[int'(cfg_addr) - 72] <= cfg_wdata[15:0];
        else if (cfg_addr >= 7'h50 && cfg_addr < 7'h54) m_w[int'(cfg_addr) - 80] <= cfg_wdata[15:0];
        else if (cfg_addr == 7'h58) m_set <= int'(cfg_wdata[1:0]);
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_tag, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      bit eg;
      eg = acc_valid && m_ok(acc_kind, acc_addr);
      chk("model grant", {31'd0, acc_grant}, {31'd0, eg});
      chk("model deny", {31'd0, acc_deny}, {31'd0, acc_valid && !eg});
      chk("model pending", {31'd0, trap_pending}, {31'd0, m_pend});
      chk("model kind", {30'd0, trap_kind}, {30'd0, m_kind});
      chk("model addr", trap_addr, m_taddr);
    end
  end

  task automatic cfg_write(input logic [6:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic probe(input logic [1:0] k, input logic [31:0] a, input bit exp);
    @(posedge clk); #1;
    acc_valid = 1'b1; acc_kind = k; acc_addr = a;
    @(negedge clk);
    chk("grant", {31'd0, acc_grant}, {31'd0, exp});
    chk("deny", {31'd0, acc_deny}, {31'd0, !exp});
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  task automatic check_trap(input bit p, input logic [1:0] k, input logic [31:0] a);
    @(negedge clk);
    chk("trap_pending", {31'd0, trap_pending}, {31'd0, p});
    chk("trap_kind", {30'd0, trap_kind}, {30'd0, k});
    chk("trap_addr", trap_addr, a);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_kind = '0; acc_addr = '0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;
    cmp_on = 1'b1;

    // R3: reset state, nothing granted, no trap recorded
    cur_tag = "R3";
    check_trap(1'b0, 2'd0, 32'h0);
    probe(2'd0, 32'h1000, 1'b0);
    probe(2'd1, 32'h0, 1'b0);
    cfg_write(7'h59, 32'h0);

    // R1: window edges and ignored bound low bits
    cur_tag = "R1";
    cfg_write(7'h04, 32'h1000);
    cfg_write(7'h05, 32'h2000);
    cfg_write(7'h40, 32'h4);
    probe(2'd0, 32'h1000, 1'b1);
    probe(2'd0, 32'h1FFC, 1'b1);
    probe(2'd0, 32'h2000, 1'b0);
    probe(2'd0, 32'h0FFC, 1'b0);
    cfg_write(7'h2A, 32'h3007);
    cfg_write(7'h2B, 32'h3105);
    cfg_write(7'h48, 32'h20);
    probe(2'd1, 32'h3000, 1'b1);
    probe(2'd1, 32'h30FF, 1'b1);
    probe(2'd1, 32'h3100, 1'b0);

    // R10: pools do not cross over
    cur_tag = "R10";
    probe(2'd1, 32'h1800, 1'b0);
    probe(2'd0, 32'h3050, 1'b0);
    probe(2'd2, 32'h3000, 1'b0);

    // R2 / R8: set 1 has write-only access to data window 5
    cur_tag = "R2";
    cfg_write(7'h51, 32'h20);
    cur_tag = "R8";
    cfg_write(7'h58, 32'h1);
    probe(2'd2, 32'h3000, 1'b1);
    probe(2'd3, 32'h3008, 1'b1);
    probe(2'd1, 32'h3000, 1'b0);
    probe(2'd0, 32'h1000, 1'b0);
    cfg_write(7'h58, 32'h0);
    probe(2'd0, 32'h1000, 1'b1);

    // R6: first violation held
    cur_tag = "R6";
    cfg_write(7'h59, 32'h0);
    check_trap(1'b0, trap_kind, trap_addr);
    probe(2'd0, 32'h2000, 1'b0);
    check_trap(1'b1, 2'd3, 32'h2000);
    probe(2'd1, 32'h0, 1'b0);
    check_trap(1'b1, 2'd3, 32'h2000);

    // R5: trap kind codes
    cur_tag = "R5";
    cfg_write(7'h59, 32'h0);
    probe(2'd2, 32'h3000, 1'b0);
    check_trap(1'b1, 2'd2, 32'h3000);
    cfg_write(7'h59, 32'h0);
    probe(2'd1, 32'h4000, 1'b0);
    check_trap(1'b1, 2'd1, 32'h4000);

    // R7: clear coinciding with a denial, then plain clear
    cur_tag = "R7";
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = 7'h59; cfg_wdata = '0;
    acc_valid = 1'b1; acc_kind = 2'd1; acc_addr = 32'h5000;
    @(posedge clk); #1;
    cfg_we = 1'b0; acc_valid = 1'b0;
    check_trap(1'b1, 2'd1, 32'h5000);
    cfg_write(7'h59, 32'h0);
    check_trap(1'b0, 2'd1, 32'h5000);

    // R4: no access presented, no answer
    cur_tag = "R4";
    @(posedge clk); #1;
    acc_valid = 1'b0; acc_kind = 2'd0; acc_addr = 32'h1000;
    @(negedge clk);
    chk("grant idle", {31'd0, acc_grant}, 32'd0);
    chk("deny idle", {31'd0, acc_deny}, 32'd0);
    check_trap(1'b0, 2'd1, 32'h5000);

    // R9: writes outside the map change nothing
    cur_tag = "R9";
    cfg_write(7'h10, 32'h0);
    cfg_write(7'h11, 32'hFFFF8);
    cfg_write(7'h44, 32'hFF);
    cfg_write(7'h5F, 32'h0);
    cfg_write(7'h7F, 32'hFFFF_FFFF);
    probe(2'd0, 32'h3000, 1'b0);
    probe(2'd0, 32'h1000, 1'b1);
    probe(2'd1, 32'h3000, 1'b1);

    // R3: random traffic against the model
    cur_tag = "R3";
    repeat (2500) begin
      int r;
      @(posedge clk); #1;
      r = int'($urandom % 8);
      cfg_we = ($urandom % 4) == 0;
      case (r)
        0, 1, 2: begin cfg_addr = 7'($urandom % 64); cfg_wdata = $urandom % 32'h9000; end
        3, 4, 5: begin cfg_addr = 7'(64 + $urandom % 24); cfg_wdata = $urandom; end
        6:       begin cfg_addr = 7'h58; cfg_wdata = $urandom; end
        default: begin cfg_addr = 7'(89 + $urandom % 39); cfg_wdata = $urandom; end
      endcase
      acc_valid = ($urandom % 4) != 0;
      acc_kind  = 2'($urandom % 4);
      acc_addr  = $urandom % 32'h9000;
    end
    @(posedge clk); #1;
    cfg_we = 1'b0; acc_valid = 1'b0;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule